// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable ratio of 64·N + A and produces a single-cycle pulse once per division cycle. Internally, a prescaler divides by either 64 or 65. A swallow counter keeps the prescaler at 65 for the first A prescaler periods of each cycle and at 64 for the rest. A main counter ends the cycle after N prescaler periods. The result is a fine-grained ratio without one wide modulo counter.

Software-side logic presents new N and A values with a one-cycle load strobe. Each load is checked against the legal ranges. A legal pair goes into a staging register and is used from the next cycle boundary onward, so a running division cycle always completes with the ratio it started with. An illegal pair is refused, the staged values stay as they were, and an error flag rises.

Top module: `psw_divider`

## Requirements
- R1: With a staged pair N, A, the interval between successive `div_pulse` assertions is exactly 64·N + A input clock cycles.
- R2: `div_pulse` is high for exactly one input clock cycle per division cycle.
- R3: Within a cycle, the prescaler runs at modulus 65 for the first A prescaler periods and at modulus 64 for the remaining N − A periods. This holds at the extremes A = 0 and A = N − 1.
- R4: While `rst` is high at a clock edge, `div_pulse` and `cfg_err` are 0 and the staged pair becomes N = 5, A = 0. The first pulse follows exactly 320 clock edges after the first edge with `rst` low.
- R5: A load accepted during a division cycle leaves that cycle's length unchanged. The new ratio applies from the next boundary.
- R6: When several legal loads arrive within one division cycle, only the last one takes effect at the boundary.
- R7: A load is refused when N < 5 or A ≥ N. On the edge after the strobe, `cfg_err` reads 1 and the staged pair keeps its previous value.
- R8: A legal load (5 ≤ N ≤ 4095, A ≤ 63, A < N) clears `cfg_err` on the edge after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Strobe that presents a new N, A pair |
| n_in | input | 12 | Main counter preset N |
| a_in | input | 6 | Swallow preset A |
| div_pulse | output | 1 | One-cycle pulse per division cycle |
| cfg_err | output | 1 | Result of the most recent load; 1 means it was refused |

## Verification
The bench builds the block with its default parameters: base modulus 64, a 12-bit main counter, a 6-bit swallow counter and a minimum N of 5. Keeping N mostly at 20 or below gives division cycles of a few hundred to about thirteen hundred clocks. That makes dozens of boundary crossings affordable, including mid-cycle reloads, overwritten loads and the legal A = N − 1 edge. Directed loads cover N = 64 with A = 63, a refused pair at the N = 5 floor, and A equal to or above N.

// File: rtl/psw_divider.sv
module psw_divider #(
  parameter int M_BASE = 64,
  parameter int N_W    = 12,
  parameter int A_W    = 6,
  parameter int N_MIN  = 5,
  parameter int N_RST  = 5,
  parameter int A_RST  = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [N_W-1:0] n_in,
  input  logic [A_W-1:0] a_in,
  output logic           div_pulse,
  output logic           cfg_err
);
  localparam int P_W = $clog2(M_BASE + 1);

  logic [P_W-1:0] pre_cnt;
  logic [N_W-1:0] n_cnt, n_sh;
  logic [A_W-1:0] s_cnt, a_sh;

  wire [P_W-1:0] pre_last = (s_cnt != '0) ? P_W'(M_BASE) : P_W'(M_BASE - 1);
  wire pre_tick = (pre_cnt == pre_last);
  wire cyc_end  = pre_tick && (n_cnt == N_W'(1));
  wire cfg_ok   = (n_in >= N_W'(N_MIN)) && (N_W'(a_in) < n_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt   <= '0;
      n_cnt     <= N_W'(N_RST);
      s_cnt     <= A_W'(A_RST);
      n_sh      <= N_W'(N_RST);
      a_sh      <= A_W'(A_RST);
      div_pulse <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      div_pulse <= cyc_end;
      if (load) begin
        cfg_err <= !cfg_ok;
        if (cfg_ok) begin
          n_sh <= n_in;
          a_sh <= a_in;
        end
      end
      if (pre_tick) begin
        pre_cnt <= '0;
        if (cyc_end) begin
          n_cnt <= n_sh;
          s_cnt <= a_sh;
        end else begin
          n_cnt <= n_cnt - N_W'(1);
          s_cnt <= s_cnt - A_W'(s_cnt != '0);
        end
      end else begin
        pre_cnt <= pre_cnt + P_W'(1);
      end
    end
  end
endmodule

module psw_divider_chk #(
  parameter int M_BASE = 64,
  parameter int N_W    = 12,
  parameter int A_W    = 6,
  parameter int N_MIN  = 5,
  parameter int P_W    = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           load,
  input logic [N_W-1:0] n_in,
  input logic [A_W-1:0] a_in,
  input logic           div_pulse,
  input logic           cfg_err,
  input logic [P_W-1:0] pre_cnt,
  input logic [N_W-1:0] n_cnt,
  input logic [N_W-1:0] n_sh,
  input logic [A_W-1:0] s_cnt,
  input logic [A_W-1:0] a_sh
);
  logic legal;
  assign legal = (int'(n_in) >= N_MIN) && (int'(a_in) < int'(n_in));

  a_r2_pulse_one_wide: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);
  a_r3_prescaler_bound: assert property (@(posedge clk) disable iff (rst)
    int'(pre_cnt) <= M_BASE);
  a_r3_swallow_below_main: assert property (@(posedge clk) disable iff (rst)
    int'(s_cnt) < int'(n_cnt));
  a_r1_pulse_at_boundary: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> pre_cnt == '0);
  a_r7_refused_load_kept: assert property (@(posedge clk) disable iff (rst)
    (load && !legal) |=> cfg_err && $stable(n_sh) && $stable(a_sh));
  a_r8_legal_load_staged: assert property (@(posedge clk) disable iff (rst)
    (load && legal) |=> !cfg_err && n_sh == $past(n_in) && a_sh == $past(a_in));
endmodule

bind psw_divider psw_divider_chk #(
  .M_BASE(M_BASE), .N_W(N_W), .A_W(A_W), .N_MIN(N_MIN), .P_W(P_W)
) u_chk (
  .clk(clk), .rst(rst), .load(load), .n_in(n_in), .a_in(a_in),
  .div_pulse(div_pulse), .cfg_err(cfg_err), .pre_cnt(pre_cnt),
  .n_cnt(n_cnt), .n_sh(n_sh), .s_cnt(s_cnt), .a_sh(a_sh)
);

// File: tb/test_psw_divider.sv
`timescale 1ns/1ps
module test_psw_divider;
  logic clk = 1'b0;
  logic rst, load;
  logic [11:0] n_in;
  logic [5:0]  a_in;
  logic div_pulse, cfg_err;
  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  int t0, cur;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  psw_divider i_psw_divider (
    .clk(clk), .rst(rst), .load(load), .n_in(n_in), .a_in(a_in),
    .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  function automatic bit legal(int n, int a);
    return n >= 5 && n <= 4095 && a <= 63 && a < n;
  endfunction
  function automatic int ratio(int n, int a);
    return 64 * n + a;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int t);
    do @(negedge clk); while (!div_pulse);
    t = cyc;
  endtask

  task automatic after_pulse(input int want, input string req);
    int t;
    wait_pulse(t);
    chk(t - t0 == want, req, t - t0, want);
    t0 = t;
    @(negedge clk);
    chk(div_pulse == 1'b0, "R2", int'(div_pulse), 0);
  endtask

  task automatic apply(input int n, input int a);
    bit ok = legal(n, a);
    int nr = ok ? ratio(n, a) : cur;
    load = 1'b1; n_in = 12'(n); a_in = 6'(a);
    @(negedge clk);
    load = 1'b0;
    chk(cfg_err == !ok, ok ? "R8" : "R7", int'(cfg_err), int'(!ok));
    after_pulse(cur, "R5");
    after_pulse(nr, ok ? "R1" : "R7");
    cur = nr;
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; load = 1'b0; n_in = '0; a_in = '0;
    repeat (3) @(negedge clk);
    chk(div_pulse == 1'b0, "R4", int'(div_pulse), 0);
    chk(cfg_err == 1'b0, "R4", int'(cfg_err), 0);
    rst = 1'b0;
    t0 = 0;
    cur = 320;
    after_pulse(320, "R4");

    apply(5, 4);    // R3 largest swallow for N=5
    apply(6, 0);    // R3 no swallow
    apply(64, 63);  // R3 widest swallow
    apply(4, 0);    // R7 N below floor
    apply(10, 10);  // R7 A equal to N
    apply(10, 20);  // R7 A above N
    apply(0, 0);    // R7
    apply(9, 2);    // R8 clears the flag

    // R6: two loads inside one cycle, the second must win
    load = 1'b1; n_in = 12'd4095; a_in = 6'd0;
    @(negedge clk);
    n_in = 12'd7; a_in = 6'd3;
    @(negedge clk);
    load = 1'b0;
    after_pulse(cur, "R5");
    after_pulse(ratio(7, 3), "R6");
    cur = ratio(7, 3);

    for (int i = 0; i < 24; i++) begin
      int n = 5 + int'($urandom_range(15));
      int a = (i % 5 == 4) ? n + int'($urandom_range(3))
                           : int'($urandom_range(n - 1));
      apply(n, a);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule